// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block holds the per-endpoint status and control words of a full-speed USB device controller: eight 16-bit registers, one per endpoint, read and written by the CPU through a simple word-addressed port. The transaction engine reports events into the bank through per-endpoint strobes. These are a completed reception (with a qualifier saying whether it was a SETUP), a completed transmission, and an advance of either data toggle. The bank turns these events into sticky flags and a per-endpoint interrupt request.

Each bit has its own CPU write behaviour, chosen so that software never needs a read-modify-write sequence. The two completion flags can only be cleared, and writing 1 leaves them alone. Toggle bits and handshake status fields invert where a 1 is written. The setup indicator cannot be written. The remaining configuration fields are ordinary storage. When a USB bus reset arrives, or when software forces one, every field is cleared except the completion flags. This means a completion that lands just before a bus reset is still reported.

Top module: `usb_ep_bank`

## Requirements
- R1: After `rst_n` is low at a clock edge, every register reads 0x0000 and `ep_irq` is all zero.
- R2: `bus_rdata` always shows the register selected by `bus_addr`, with the layout: bit 15 receive-complete, 14 receive toggle, 13:12 receive status, 11 setup indicator, 10:9 endpoint type, 8 endpoint kind, 7 transmit-complete, 6 transmit toggle, 5:4 transmit status, 3:0 endpoint address.
- R3: A strobe on `ev_rx_ok[i]` sets bit 15 of register i and loads bit 11 with `ev_rx_setup[i]`. A strobe on `ev_tx_ok[i]` sets bit 7. When such a strobe coincides with a CPU write of 0 to the same flag, the flag ends up set.
- R4: A CPU write with 0 in bit 15 or bit 7 clears that flag. A write with 1 there leaves the flag unchanged.
- R5: In bits 14:12 and 6:4, a written 1 inverts the bit and a written 0 leaves it unchanged. `ev_rx_tog_adv[i]` inverts bit 14 and `ev_tx_tog_adv[i]` inverts bit 6. A write and a strobe on the same bit in the same cycle cancel each other.
- R6: Bits 10:8 and 3:0 take the written value on every CPU write.
- R7: CPU writes never change bit 11.
- R8: A cycle with `usb_bus_rst` or `force_rst` high clears every bit except 15 and 7 in all registers. This overrides any same-cycle write or event on those bits. Bits 15 and 7 keep their normal behaviour during that cycle.
- R9: `ep_irq[i]` is high exactly when bit 15 or bit 7 of register i is set.
- R10: A CPU write changes only the register selected by `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word index of the register (byte offset / 4) |
| bus_we | input | 1 | CPU write strobe |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | Selected register contents |
| ev_rx_ok | input | 8 | Per endpoint: reception completed correctly |
| ev_rx_setup | input | 8 | Per endpoint: the completed reception was a SETUP |
| ev_tx_ok | input | 8 | Per endpoint: transmission completed correctly |
| ev_rx_tog_adv | input | 8 | Per endpoint: advance receive data toggle |
| ev_tx_tog_adv | input | 8 | Per endpoint: advance transmit data toggle |
| usb_bus_rst | input | 1 | USB bus reset pulse |
| force_rst | input | 1 | Software-forced bus reset |
| ep_irq | output | 8 | Per endpoint: OR of the two completion flags |

## Verification
Each register is read through the combinational port, so a wrong stored bit appears on `bus_rdata` in the same cycle that the register is addressed. The interrupt vector shows a wrong completion flag on every endpoint at once. A wrong flag appears one clock after the event or write that caused it. A toggle or status field that is inverted or stuck shows up after the next write or strobe to that field, once the field is read back. A bus reset that wipes a completion flag drops `ep_irq` on the next clock.

// File: rtl/ep_bank_pkg.sv
// Shared definitions for the endpoint register bank.
// Assumes a 16-bit register word whose field order is fixed by the
// transaction engine and software that decode it.
package ep_bank_pkg;

    localparam int REG_W = 16;

    // Field layout, most significant first; the order is part of the interface.
    typedef struct packed {
        logic       rx_done;   // 15 receive-complete flag (clear-only)
        logic       rx_tog;    // 14 receive data toggle (invert-on-1)
        logic [1:0] rx_stat;   // 13:12 receive handshake status (invert-on-1)
        logic       setup;     // 11 last reception was SETUP (read-only)
        logic [1:0] ep_type;   // 10:9 endpoint type (read/write)
        logic       ep_kind;   // 8 endpoint kind (read/write)
        logic       tx_done;   // 7 transmit-complete flag (clear-only)
        logic       tx_tog;    // 6 transmit data toggle (invert-on-1)
        logic [1:0] tx_stat;   // 5:4 transmit handshake status (invert-on-1)
        logic [3:0] ep_addr;   // 3:0 endpoint address (read/write)
    } ep_reg_t;

    // Bits that survive a bus reset.
    localparam logic [REG_W-1:0] KEEP_ON_BUS_RST = 16'h8080;

endpackage

// File: rtl/usb_ep_wr_decode.sv
// Turns the CPU write strobe and word address into one write enable per
// endpoint register. Assumes at most one register is written per cycle.
module usb_ep_wr_decode #(
    parameter int N_EP   = 8,
    parameter int ADDR_W = $clog2(N_EP)
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [N_EP-1:0]   wr_sel
);

    // One enable per endpoint, raised only for the addressed one.
    for (genvar g = 0; g < N_EP; g++) begin : g_sel
        assign wr_sel[g] = bus_we && (bus_addr == ADDR_W'(g));
    end

    // R10: never more than one register written at a time
    always_comb begin
        a_r10_one_target: assert ($onehot0(wr_sel));
    end

endmodule

// File: rtl/usb_ep_rd_mux.sv
// Selects the addressed register word for the CPU read port.
// Assumes an index beyond the last endpoint reads as zero.
module usb_ep_rd_mux #(
    parameter int N_EP   = 8,
    parameter int REG_W  = 16,
    parameter int ADDR_W = $clog2(N_EP)
) (
    input  logic [N_EP-1:0][REG_W-1:0] regs,
    input  logic [ADDR_W-1:0]          bus_addr,
    output logic [REG_W-1:0]           bus_rdata
);

    // Plain indexed read with a guard for unused indices.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_EP; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = regs[i];
        end
    end

endmodule

// File: rtl/usb_ep_reg.sv
// One endpoint status/control register with per-field write semantics.
// Assumes event strobes are single-cycle and already qualified by the
// transaction engine (only successful transactions are reported).
module usb_ep_reg
    import ep_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             hw_rx_done,
    input  logic             hw_rx_setup,
    input  logic             hw_tx_done,
    input  logic             hw_rx_adv,
    input  logic             hw_tx_adv,
    input  logic             bus_rst,
    output logic [REG_W-1:0] reg_q,
    output logic             irq
);

    ep_reg_t q, d, w;
    logic    unused_setup_wr;

    assign w               = ep_reg_t'(wdata);
    assign unused_setup_wr = w.setup;

    // Next-state rules: flags set-dominant, toggles XOR, config plain, bus reset clears.
    always_comb begin
        d = q;
        if (hw_rx_done)             d.rx_done = 1'b1;
        else if (wr_en && !w.rx_done) d.rx_done = 1'b0;
        if (hw_tx_done)             d.tx_done = 1'b1;
        else if (wr_en && !w.tx_done) d.tx_done = 1'b0;

        if (bus_rst) begin
            d.rx_tog  = 1'b0;
            d.rx_stat = '0;
            d.setup   = 1'b0;
            d.ep_type = '0;
            d.ep_kind = 1'b0;
            d.tx_tog  = 1'b0;
            d.tx_stat = '0;
            d.ep_addr = '0;
        end else begin
            d.rx_tog  = q.rx_tog ^ (wr_en & w.rx_tog) ^ hw_rx_adv;
            d.tx_tog  = q.tx_tog ^ (wr_en & w.tx_tog) ^ hw_tx_adv;
            d.rx_stat = q.rx_stat ^ (wr_en ? w.rx_stat : 2'b00);
            d.tx_stat = q.tx_stat ^ (wr_en ? w.tx_stat : 2'b00);
            if (hw_rx_done) d.setup = hw_rx_setup;
            if (wr_en) begin
                d.ep_type = w.ep_type;
                d.ep_kind = w.ep_kind;
                d.ep_addr = w.ep_addr;
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_q = q;
    assign irq   = q.rx_done | q.tx_done;

    // R3: a reception strobe always leaves the flag set
    a_r3_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rx_done |=> q.rx_done);
    // R3: transmit strobe likewise
    a_r3_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        hw_tx_done |=> q.tx_done);
    // R4: writing 1 to a flag keeps it
    a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w.tx_done && !hw_tx_done) |=> (q.tx_done == $past(q.tx_done)));
    // R4: writing 0 clears it
    a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w.rx_done && !hw_rx_done) |=> !q.rx_done);
    // R5: a lone written 1 flips the receive toggle
    a_r5_tog_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rst && wr_en && w.rx_tog && !hw_rx_adv) |=> (q.rx_tog != $past(q.rx_tog)));
    // R7: setup indicator moves only on a reception or bus reset
    a_r7_setup_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rx_done && !bus_rst) |=> $stable(q.setup));
    // R8: bus reset leaves only the two flags
    a_r8_bus_rst: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> ((reg_q & ~KEEP_ON_BUS_RST) == '0));

endmodule

// File: rtl/usb_ep_bank.sv
// Bank of endpoint status/control registers with a word-addressed CPU port.
// Assumes one CPU access per cycle and single-cycle event strobes; a USB
// bus reset and a forced reset act identically.
module usb_ep_bank
    import ep_bank_pkg::*;
#(
    parameter int N_EP   = 8,
    parameter int ADDR_W = $clog2(N_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_EP-1:0]   ev_rx_ok,
    input  logic [N_EP-1:0]   ev_rx_setup,
    input  logic [N_EP-1:0]   ev_tx_ok,
    input  logic [N_EP-1:0]   ev_rx_tog_adv,
    input  logic [N_EP-1:0]   ev_tx_tog_adv,
    input  logic              usb_bus_rst,
    input  logic              force_rst,
    output logic [N_EP-1:0]   ep_irq
);

    logic [N_EP-1:0]             wr_sel;
    logic [N_EP-1:0][REG_W-1:0]  regs;
    logic                        any_bus_rst;

    // Both reset sources share one effect.
    assign any_bus_rst = usb_bus_rst | force_rst;

    usb_ep_wr_decode #(.N_EP(N_EP), .ADDR_W(ADDR_W)) u_dec (
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .wr_sel  (wr_sel)
    );

    for (genvar g = 0; g < N_EP; g++) begin : g_ep
        usb_ep_reg u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_sel[g]),
            .wdata      (bus_wdata),
            .hw_rx_done (ev_rx_ok[g]),
            .hw_rx_setup(ev_rx_setup[g]),
            .hw_tx_done (ev_tx_ok[g]),
            .hw_rx_adv  (ev_rx_tog_adv[g]),
            .hw_tx_adv  (ev_tx_tog_adv[g]),
            .bus_rst    (any_bus_rst),
            .reg_q      (regs[g]),
            .irq        (ep_irq[g])
        );
    end

    usb_ep_rd_mux #(.N_EP(N_EP), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_rd (
        .regs     (regs),
        .bus_addr (bus_addr),
        .bus_rdata(bus_rdata)
    );

    // R9: interrupt of the addressed endpoint matches its flags on the read port
    a_r9_irq_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq[bus_addr] == (bus_rdata[15] | bus_rdata[7]));
    // R1: the cycle after reset nothing is pending
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (ep_irq == '0));

endmodule

// File: tb/usb_ep_bank_bench.sv
module usb_ep_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  rxd = '0, su = '0, txd = '0, rxa = '0, txa = '0;
    logic        ur = 1'b0, fr = 1'b0;
    logic [7:0]  ep_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [8];

    always #10 clk = ~clk;

    usb_ep_bank u_usb_ep_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_ok(rxd), .ev_rx_setup(su), .ev_tx_ok(txd),
        .ev_rx_tog_adv(rxa), .ev_tx_tog_adv(txa),
        .usb_bus_rst(ur), .force_rst(fr), .ep_irq(ep_irq)
    );

    // Expected next value of one register, from the requirements.
    function automatic logic [15:0] nxt(input logic [15:0] o, input bit we,
        input logic [15:0] w, input bit rd, input bit s, input bit td,
        input bit ra, input bit ta, input bit br);
        logic [15:0] n;
        n = o;
        if (rd) n[15] = 1'b1; else if (we && !w[15]) n[15] = 1'b0;
        if (td) n[7]  = 1'b1; else if (we && !w[7])  n[7]  = 1'b0;
        if (br) begin
            n[14:8] = '0;
            n[6:0]  = '0;
        end else begin
            n[14]    = o[14] ^ (we & w[14]) ^ ra;
            n[6]     = o[6]  ^ (we & w[6])  ^ ta;
            n[13:12] = o[13:12] ^ (we ? w[13:12] : 2'b00);
            n[5:4]   = o[5:4]   ^ (we ? w[5:4]   : 2'b00);
            if (rd) n[11] = s;
            if (we) begin
                n[10:8] = w[10:8];
                n[3:0]  = w[3:0];
            end
        end
        return n;
    endfunction

    // One clock: the model takes the inputs present at the edge, then pulses drop.
    task automatic tick();
        @(posedge clk);
        for (int i = 0; i < 8; i++)
            if (!rst_n) model[i] = '0;
            else model[i] = nxt(model[i], bus_we && (bus_addr == 3'(i)), bus_wdata,
                                rxd[i], su[i], txd[i], rxa[i], txa[i], ur | fr);
        #1;
        bus_we = 1'b0; rxd = '0; su = '0; txd = '0; rxa = '0; txa = '0;
        ur = 1'b0; fr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input int idx, input string req, input logic [15:0] exp);
        bus_addr = 3'(idx);
        #2;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wr(input int idx, input logic [15:0] v);
        bus_addr = 3'(idx); bus_we = 1'b1; bus_wdata = v;
    endtask

    function automatic logic [7:0] irq_exp();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = model[i][15] | model[i][7];
        return v;
    endfunction

    initial begin
        #(20 * 100000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 8; i++) model[i] = 16'hFFFF;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        #2;
        // R1: everything zero after reset
        for (int i = 0; i < 8; i++) rd(i, "R1", 16'h0000);
        chk("R1 irq", {8'h00, ep_irq}, 16'h0000);

        // R6: configuration fields take the written value
        wr(3, 16'h070F); tick();
        rd(3, "R6", 16'h070F);
        rd(2, "R10", 16'h0000);
        rd(4, "R10", 16'h0000);

        // R3: completion events and setup qualifier
        rxd[3] = 1; su[3] = 1; txd[3] = 1; tick();
        rd(3, "R3", 16'h8F8F);
        chk("R9", {8'h00, ep_irq}, 16'h0008);

        // R4: write 1 keeps rx flag, write 0 clears tx flag; R7 setup not writable
        wr(3, 16'h870F); tick();
        rd(3, "R4", 16'h8F0F);
        chk("R7", {15'd0, bus_rdata[11]}, 16'h0001);

        // R3: set wins over same-cycle clear; setup reloaded from qualifier
        wr(3, 16'h070F); rxd[3] = 1; su[3] = 0; tick();
        rd(3, "R3 set-wins", 16'h870F);

        // R5: invert-on-1 for toggles and status
        wr(3, 16'hF77F); tick();
        rd(3, "R5", 16'hF77F);
        wr(3, 16'h971F); tick();
        rd(3, "R5", 16'hE76F);
        rxa[3] = 1; txa[3] = 1; tick();
        rd(3, "R5 hw adv", 16'hA72F);
        wr(3, 16'hC70F); rxa[3] = 1; tick();
        rd(3, "R5 cancel", 16'hA72F);

        // R8: bus reset clears all but the flags, overriding a same-cycle write
        wr(3, 16'h8F7F); ur = 1; tick();
        rd(3, "R8", 16'h8000);
        wr(5, 16'h0305); txd[5] = 1; tick();
        rd(5, "R6", 16'h0385);
        fr = 1; rxa[5] = 1; tick();
        rd(5, "R8 forced", 16'h0080);
        chk("R9", {8'h00, ep_irq}, 16'h0028);

        // Sweep: pseudo-random writes and events against the model (R2).
        s = 32'h1234_5678;
        for (int it = 0; it < 1600; it++) begin
            s = s * 32'd1103515245 + 32'd12345;
            bus_addr = s[18:16];
            bus_we   = s[19];
            bus_wdata = s[31:16] ^ {s[7:0], s[15:8]};
            rxd = s[7:0] & s[15:8];
            su  = s[23:16];
            s = s * 32'd1103515245 + 32'd12345;
            txd = s[7:0] & s[15:8];
            rxa = s[23:16] & s[31:24];
            txa = s[15:8] & s[23:16];
            ur  = (s[28:24] == 5'd0);
            fr  = (s[28:24] == 5'd31);
            tick();
            rd(it % 8, "R2", model[it % 8]);
            chk("R9", {8'h00, ep_irq}, {8'h00, irq_exp()});
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule